// File: doc/BRIEF.md
# Programmable Sum-of-Products Output Macrocell

This block is one output cell of a small programmable logic array. A bank of product terms is built from an input vector: each term is the AND of whichever true or inverted input literals its mask connects. An OR gate then adds together the terms that are switched on. Two configuration bits choose how that sum reaches the pin. It can pass straight through or go through a D register, and it can be driven active-high or active-low. The feedback output returns the register value in registered mode and the pin value in combinatorial mode. The surrounding array routes that feedback into other cells' inputs.

The register has four controls: an asynchronous clear term, a synchronous set term, a test preload port that forces a chosen level, and a power-up reset. After power-up the register reads low, so the pin level depends on the chosen polarity. Once reset is released, the register ignores a programmable number of clock edges. This leaves room for input and feedback setup to be met before the first edge takes effect.

Top module: `mc_cell`

## Requirements
- R1: Mask bit `2*k` of a product term connects input `x_i[k]` and bit `2*k+1` connects its complement. Term `p` uses mask bits `p*2*N_IN` upward. A term is the AND of its connected literals, and a term with no connected literal evaluates to 1.
- R2: A product term whose `pt_en_i` bit is 0 contributes nothing to the sum. The sum is the OR of the enabled terms and is 0 when no term is enabled.
- R3: With `cfg_reg_i`=0 (combinatorial), `pin_o` equals the sum when `cfg_hi_i`=1 and its complement when `cfg_hi_i`=0, in the same cycle. `fb_o` equals `pin_o`.
- R4: With `cfg_reg_i`=1 (registered), the register takes the sum on a rising clock edge. `pin_o` is the register value when `cfg_hi_i`=1 and its complement when `cfg_hi_i`=0. `fb_o` is the register value.
- R5: When `preset_i` is high at a rising edge, the register is set to 1 regardless of the sum.
- R6: While `areset_i` is high, the register is 0 at once without a clock edge. This clear wins over both preset and preload.
- R7: While `rst_n` is low the register is 0, so a registered pin reads 0 when active-high and 1 when active-low.
- R8: After `rst_n` rises, the register ignores the first `POR_HOLD` rising edges (default 2) and stays 0. The next edge is honoured.
- R9: When `preload_en_i` is high at an honoured rising edge, the register loads `preload_val_i`. This takes priority over both preset and sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| x_i | input | N_IN | Array inputs and routed feedback |
| and_mask_i | input | N_PT*2*N_IN | Literal connections of every product term |
| pt_en_i | input | N_PT | Enable per product term |
| cfg_reg_i | input | 1 | 1 selects registered output, 0 combinatorial |
| cfg_hi_i | input | 1 | 1 selects active-high pin, 0 active-low |
| preset_i | input | 1 | Shared synchronous set term |
| areset_i | input | 1 | Shared asynchronous clear term |
| preload_en_i | input | 1 | Test preload request |
| preload_val_i | input | 1 | Level forced by preload |
| pin_o | output | 1 | Output pin value |
| fb_o | output | 1 | Feedback to the array |

## Verification
Combinatorial results (R1 to R3) and the asynchronous clear (R6) are due without any clock edge, so the bench compares them one time step after driving inputs at the falling edge. Register results (R4, R5, R8, R9) become visible after the first rising edge that follows the stimulus. The bench therefore drives at a falling edge, waits through exactly one rising edge, and samples at the next falling edge. The power-up hold is checked edge by edge: for R8 the register value is sampled after each of the `POR_HOLD` ignored edges and after the first honoured edge.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        MODE_COMB_LOW  = 2'b00,
        MODE_COMB_HIGH = 2'b01,
        MODE_REG_LOW   = 2'b10,
        MODE_REG_HIGH  = 2'b11
    } out_mode_e;

    typedef struct packed {
        logic q;
    } cell_state_t;

endpackage

// File: rtl/mc_and_array.sv
module mc_and_array #(
    parameter int N_IN = 22,
    parameter int N_PT = 16
) (
    input  logic [N_IN-1:0]        x_i,
    input  logic [N_PT*2*N_IN-1:0] mask_i,
    input  logic [N_PT-1:0]        en_i,
    output logic                   sum_o
);
    localparam int LW = 2 * N_IN;

    logic [LW-1:0]   lit;
    logic [N_PT-1:0] term;

    for (genvar k = 0; k < N_IN; k++) begin : g_lit
        assign lit[2*k]   = x_i[k];
        assign lit[2*k+1] = ~x_i[k];
    end

    for (genvar p = 0; p < N_PT; p++) begin : g_term
        logic [LW-1:0] sel;
        assign sel     = mask_i[p*LW +: LW];
        assign term[p] = en_i[p] & (&(lit | ~sel));
    end

    assign sum_o = |term;

endmodule

// File: rtl/mc_por_timer.sv
module mc_por_timer #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready_o
);
    localparam int CW = (HOLD < 1) ? 1 : $clog2(HOLD + 1);
    localparam logic [CW-1:0] START = CW'(HOLD);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= START;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign ready_o = (cnt_q == '0);

endmodule

// File: rtl/mc_out_select.sv
module mc_out_select
    import mc_pkg::*;
(
    input  out_mode_e mode_i,
    input  logic      sum_i,
    input  logic      q_i,
    output logic      pin_o,
    output logic      fb_o
);
    always_comb begin
        unique case (mode_i)
            MODE_COMB_LOW:  begin pin_o = ~sum_i; fb_o = ~sum_i; end
            MODE_COMB_HIGH: begin pin_o =  sum_i; fb_o =  sum_i; end
            MODE_REG_LOW:   begin pin_o = ~q_i;   fb_o =  q_i;   end
            default:        begin pin_o =  q_i;   fb_o =  q_i;   end
        endcase
    end

endmodule

// File: rtl/mc_cell.sv
module mc_cell
    import mc_pkg::*;
#(
    parameter int N_IN     = 22,
    parameter int N_PT     = 16,
    parameter int POR_HOLD = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        x_i,
    input  logic [N_PT*2*N_IN-1:0] and_mask_i,
    input  logic [N_PT-1:0]        pt_en_i,
    input  logic                   cfg_reg_i,
    input  logic                   cfg_hi_i,
    input  logic                   preset_i,
    input  logic                   areset_i,
    input  logic                   preload_en_i,
    input  logic                   preload_val_i,
    output logic                   pin_o,
    output logic                   fb_o
);
    logic        sum;
    logic        por_ready;
    logic        clr_n;
    logic        reg_q;
    out_mode_e   mode;
    cell_state_t st_d, st_q;

    mc_and_array #(.N_IN(N_IN), .N_PT(N_PT)) u_array (
        .x_i   (x_i),
        .mask_i(and_mask_i),
        .en_i  (pt_en_i),
        .sum_o (sum)
    );

    mc_por_timer #(.HOLD(POR_HOLD)) u_por (
        .clk    (clk),
        .rst_n  (rst_n),
        .ready_o(por_ready)
    );

    // Priority of synchronous sources: preload, then preset, then sum.
    always_comb begin
        st_d = st_q;
        if (por_ready) begin
            if (preload_en_i) begin
                st_d.q = preload_val_i;
            end else if (preset_i) begin
                st_d.q = 1'b1;
            end else begin
                st_d.q = sum;
            end
        end
    end

    // The clear term and power-up reset share the asynchronous path.
    assign clr_n = rst_n & ~areset_i;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_q = st_q.q;
    assign mode  = out_mode_e'({cfg_reg_i, cfg_hi_i});

    mc_out_select u_sel (
        .mode_i(mode),
        .sum_i (sum),
        .q_i   (reg_q),
        .pin_o (pin_o),
        .fb_o  (fb_o)
    );

endmodule

// File: rtl/mc_cell_chk.sv
module mc_cell_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_reg,
    input logic cfg_hi,
    input logic preset,
    input logic areset,
    input logic preload_en,
    input logic preload_val,
    input logic pin,
    input logic fb,
    input logic q,
    input logic sum,
    input logic ready
);
    assert_comb_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_reg |-> (pin == (cfg_hi ? sum : !sum)) && (fb == pin));

    assert_reg_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reg |-> (pin == (cfg_hi ? q : !q)) && (fb == q));

    assert_preset_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !preload_en && preset && !areset) |=> (q || areset));

    assert_areset_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        areset |-> !q);

    assert_hold_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !q);

    assert_preload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && preload_en && !areset) |=> (areset || q == $past(preload_val)));

endmodule

bind mc_cell mc_cell_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_reg    (cfg_reg_i),
    .cfg_hi     (cfg_hi_i),
    .preset     (preset_i),
    .areset     (areset_i),
    .preload_en (preload_en_i),
    .preload_val(preload_val_i),
    .pin        (pin_o),
    .fb         (fb_o),
    .q          (reg_q),
    .sum        (sum),
    .ready      (por_ready)
);

// File: tb/mc_cell_test.sv
module mc_cell_test;
    localparam int N_IN = 22;
    localparam int N_PT = 16;
    localparam int HOLD = 2;
    localparam int LW   = 2 * N_IN;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [N_IN-1:0]        x;
    logic [N_PT*LW-1:0]     mask;
    logic [N_PT-1:0]        pt_en;
    logic                   cfg_reg, cfg_hi, preset, areset, pl_en, pl_val;
    logic                   pin, fb;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mc_cell #(.N_IN(N_IN), .N_PT(N_PT), .POR_HOLD(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .x_i(x), .and_mask_i(mask), .pt_en_i(pt_en),
        .cfg_reg_i(cfg_reg), .cfg_hi_i(cfg_hi), .preset_i(preset), .areset_i(areset),
        .preload_en_i(pl_en), .preload_val_i(pl_val), .pin_o(pin), .fb_o(fb)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    // Connect literal: input k, true (neg=0) or complement (neg=1), into term p.
    task automatic connect(input int p, input int k, input bit neg);
        mask[p*LW + 2*k + (neg ? 1 : 0)] = 1'b1;
    endtask

    task automatic test_power_up();
        rst_n = 1'b0; cfg_reg = 1'b1; cfg_hi = 1'b1;
        settle();
        check("R7 reset pin active-high", pin, 1'b0);
        check("R7 reset fb", fb, 1'b0);
        cfg_hi = 1'b0; settle();
        check("R7 reset pin active-low", pin, 1'b1);
        cfg_hi = 1'b1;
        pt_en = 16'h0001;
        tick();
        rst_n = 1'b1;
        tick();
        check("R8 first edge ignored", fb, 1'b0);
        tick();
        check("R8 second edge ignored", fb, 1'b0);
        tick();
        check("R8 edge after hold honoured", fb, 1'b1);
    endtask

    task automatic test_terms();
        cfg_reg = 1'b0; cfg_hi = 1'b1;
        mask = '0; pt_en = 16'h0001;
        settle();
        check("R1 empty term is one", pin, 1'b1);
        connect(0, 0, 1'b0); connect(0, 1, 1'b1);
        x = '0; x[0] = 1'b1; settle();
        check("R1 x0 & ~x1 true", pin, 1'b1);
        x[1] = 1'b1; settle();
        check("R1 x0 & ~x1 with x1 set", pin, 1'b0);
        x = '0; settle();
        check("R1 x0 & ~x1 with x0 clear", pin, 1'b0);
    endtask

    task automatic test_sum();
        cfg_reg = 1'b0; cfg_hi = 1'b1;
        mask = '0; pt_en = 16'h0000; x = '0;
        settle();
        check("R2 no term enabled", pin, 1'b0);
        connect(0, 2, 1'b0); connect(1, 3, 1'b0);
        pt_en = 16'h0003; x[3] = 1'b1; settle();
        check("R2 second term drives sum", pin, 1'b1);
        pt_en = 16'h0001; settle();
        check("R2 disabled term ignored", pin, 1'b0);
        x[2] = 1'b1; settle();
        check("R2 first term drives sum", pin, 1'b1);
    endtask

    task automatic test_comb_polarity();
        cfg_reg = 1'b0; cfg_hi = 1'b0;
        mask = '0; pt_en = 16'h0001; settle();
        check("R3 active-low pin", pin, 1'b0);
        check("R3 fb follows pin", fb, 1'b0);
        pt_en = 16'h0000; settle();
        check("R3 active-low pin of zero sum", pin, 1'b1);
        check("R3 fb follows pin zero sum", fb, 1'b1);
    endtask

    task automatic test_registered();
        cfg_reg = 1'b1; cfg_hi = 1'b1;
        mask = '0; pt_en = 16'h0001;
        tick();
        check("R4 register captures one", pin, 1'b1);
        pt_en = 16'h0000; settle();
        check("R4 pin held between edges", pin, 1'b1);
        tick();
        check("R4 register captures zero", fb, 1'b0);
        pt_en = 16'h0001; cfg_hi = 1'b0;
        tick();
        check("R4 active-low pin", pin, 1'b0);
        check("R4 fb is register value", fb, 1'b1);
        cfg_hi = 1'b1;
    endtask

    task automatic test_preset();
        cfg_reg = 1'b1; cfg_hi = 1'b1; pt_en = 16'h0000;
        tick();
        check("R5 cleared before preset", fb, 1'b0);
        preset = 1'b1;
        tick();
        check("R5 preset sets register", fb, 1'b1);
        preset = 1'b0;
    endtask

    task automatic test_areset();
        cfg_reg = 1'b1; cfg_hi = 1'b1; pt_en = 16'h0001;
        tick();
        check("R6 register set before clear", fb, 1'b1);
        areset = 1'b1; settle();
        check("R6 clear without clock", fb, 1'b0);
        preset = 1'b1; pl_en = 1'b1; pl_val = 1'b1;
        tick();
        check("R6 clear beats preset and preload", fb, 1'b0);
        areset = 1'b0; preset = 1'b0; pl_en = 1'b0;
        tick();
        check("R6 resumes after clear", fb, 1'b1);
    endtask

    task automatic test_preload();
        cfg_reg = 1'b1; cfg_hi = 1'b1; pt_en = 16'h0001;
        preset = 1'b1; pl_en = 1'b1; pl_val = 1'b0;
        tick();
        check("R9 preload low beats preset and sum", fb, 1'b0);
        preset = 1'b0; pt_en = 16'h0000; pl_val = 1'b1;
        tick();
        check("R9 preload high beats sum", fb, 1'b1);
        pl_en = 1'b0;
        tick();
        check("R9 normal capture after preload", fb, 1'b0);
    endtask

    initial begin
        #100000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        x = '0; mask = '0; pt_en = '0;
        cfg_reg = 1'b0; cfg_hi = 1'b1;
        preset = 1'b0; areset = 1'b0; pl_en = 1'b0; pl_val = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        test_power_up();
        test_terms();
        test_sum();
        test_comb_polarity();
        test_registered();
        test_preset();
        test_areset();
        test_preload();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule